// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block is a read-only memory with a pin-style read port. The port can serve a 16-bit word or an 8-bit byte from each location, and a level on the mode input chooses between the two. In byte mode, the pin that carries the top data bit in word mode becomes an input. It supplies the lowest bit of the byte address, so 22 address pins plus that one pin give a 23-bit byte address. The data pins have a separate high-impedance control for each lane, so a pad ring or a bus model can build true three-state pins from them. Chip enable and output enable gate those controls. The output enable can be built as active-high, as active-low, or so that it has no effect.

The contents come from an image formula that is set by a seed parameter. The depth is a parameter, so a small array can stand in for the full 4M x 16 organization in simulation. Read data passes through a register pipeline of a set number of clock cycles. This stands in for the address-to-data access time, which must stay within 100 ns. The lane enables follow chip enable, output enable and mode in the same cycle, so the shared pin can never fight an external address driver. The port is a set of plain control and data pins with no valid/ready handshake, because a ROM pin interface has no back-pressure.

Top module: `rom_bw_port`

## Requirements
- R1: With `word_mode`=1, after the access latency, `{shared_out, data_out}` equals the 16-bit image word at location `addr mod DEPTH`. In word mode `shared_in` has no effect on the data.
- R2: With `word_mode`=0, the byte address is `{addr, shared_in}`. If `shared_in`=0, `data_out[7:0]` carries bits 7:0 of the word. If `shared_in`=1, it carries bits 15:8. In both cases `data_out[14:8]` and `shared_out` read 0.
- R3: In word mode, while the port is driving, all 15 bits of `data_oe` and `shared_oe` are 1.
- R4: In byte mode, `data_oe[14:8]` and `shared_oe` are 0 in the same cycle that the mode input goes low.
- R5: While `ce_n`=1, every bit of `data_oe` and `shared_oe` is 0.
- R6: The parameter `OE_POL` selects how `oe_in` gates the outputs. With `OE_ACT_HIGH` (0), the port drives only when `oe_in`=1. With `OE_ACT_LOW` (1), it drives only when `oe_in`=0. With `OE_IGNORE` (2), `oe_in` has no effect and `ce_n`=0 alone enables the outputs. `data_oe[7:0]` are always equal to each other.
- R7: Data presented before a rising edge appears on `data_out` and `shared_out` after `LATENCY` rising edges, and not earlier. The lane enables respond without any clock delay.
- R8: The word at location a is the low 16 bits of `(a*40503 + IMG_SEED) XOR (a << 5)`.
- R9: Address bits at or above log2(DEPTH) are ignored, so locations wrap modulo `DEPTH`.
- R10: While `rst_n`=0, `data_out` and `shared_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the access pipeline |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| addr | input | 22 | Word address, or the upper byte-address bits in byte mode |
| word_mode | input | 1 | 1 selects word organization, 0 selects byte organization |
| ce_n | input | 1 | Chip enable, active low |
| oe_in | input | 1 | Output enable; its polarity is set by `OE_POL` |
| shared_in | input | 1 | Input side of the shared pin: lowest byte-address bit in byte mode |
| data_out | output | 15 | Data lanes 0 to 14 |
| data_oe | output | 15 | Drive enable for each data lane (0 means high impedance) |
| shared_out | output | 1 | Output side of the shared pin: data bit 15 in word mode |
| shared_oe | output | 1 | Drive enable for the shared pin |

## Verification
The assertions assume that `OE_POL` holds one of its three legal codes. They also assume that every input settles between clock edges, so the lane-enable checks see stable levels at each edge. The stimulus changes inputs only on falling edges. It draws its addresses over the full 22-bit range, which exercises wrap-around. It also drives `shared_in` in both modes, so the bench can see whether the shared pin is ignored in word mode and used as an address bit in byte mode.

// File: rtl/rom_bw_pkg.sv
`timescale 1ns/1ps
package rom_bw_pkg;
  typedef enum logic [1:0] {
    OE_ACT_HIGH = 2'd0,
    OE_ACT_LOW  = 2'd1,
    OE_IGNORE   = 2'd2
  } oe_pol_e;

  localparam int PIN_ADDR_W = 22;
  localparam int WORD_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int LANE_W     = WORD_W - 1;

  // Image formula: low 16 bits of (a*40503 + seed) xor (a << 5)
  function automatic logic [WORD_W-1:0] image_word(input logic [31:0] a,
                                                    input logic [WORD_W-1:0] seed);
    logic [31:0] prod;
    logic [31:0] shf;
    prod = a * 32'd40503 + {16'h0000, seed};
    shf  = a << 5;
    return prod[WORD_W-1:0] ^ shf[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/rom_addr_map.sv
`timescale 1ns/1ps
module rom_addr_map #(
  parameter int IN_W = 22,
  parameter int AW   = 8
) (
  input  logic [IN_W-1:0] addr,
  input  logic            word_mode,
  input  logic            shared_in,
  output logic [AW-1:0]   word_idx,
  output logic            hi_byte
);
  // Upper pin bits beyond the array depth are dropped: locations alias.
  assign word_idx = addr[AW-1:0];
  // The shared pin is only an address bit in byte mode.
  assign hi_byte  = !word_mode && shared_in;
endmodule

// File: rtl/rom_image.sv
`timescale 1ns/1ps
module rom_image
  import rom_bw_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          SB_W     = 2,
  parameter logic [15:0] IMG_SEED = 16'h1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     word_idx,
  input  logic [SB_W-1:0]   sb_in,
  output logic [WORD_W-1:0] word_q,
  output logic [SB_W-1:0]   sb_q
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = image_word({{(32-AW){1'b0}}, word_idx}, IMG_SEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sb_q   <= '0;
    end else begin
      word_q <= word_d;
      sb_q   <= sb_in;
    end
  end
endmodule

// File: rtl/rom_delay.sv
`timescale 1ns/1ps
module rom_delay #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rom_lane_steer.sv
`timescale 1ns/1ps
module rom_lane_steer
  import rom_bw_pkg::*;
#(
  parameter oe_pol_e OE_POL = OE_ACT_LOW
) (
  input  logic [WORD_W-1:0] word_d,
  input  logic              word_mode_d,
  input  logic              hi_byte_d,
  input  logic              word_mode,
  input  logic              ce_n,
  input  logic              oe_in,
  output logic [LANE_W-1:0] data_out,
  output logic [LANE_W-1:0] data_oe,
  output logic              shared_out,
  output logic              shared_oe
);
  localparam int UP_W = LANE_W - BYTE_W;

  logic oe_ok;
  logic drive;
  logic [BYTE_W-1:0] low_lane;

  generate
    if (OE_POL == OE_ACT_HIGH) begin : g_oe_hi
      assign oe_ok = oe_in;
    end else if (OE_POL == OE_ACT_LOW) begin : g_oe_lo
      assign oe_ok = !oe_in;
    end else begin : g_oe_ig
      assign oe_ok = 1'b1;
    end
  endgenerate

  assign drive = !ce_n && oe_ok;

  always_comb begin
    if (word_mode_d)    low_lane = word_d[BYTE_W-1:0];
    else if (hi_byte_d) low_lane = word_d[WORD_W-1:BYTE_W];
    else                low_lane = word_d[BYTE_W-1:0];
  end

  assign data_out[BYTE_W-1:0]      = low_lane;
  assign data_out[LANE_W-1:BYTE_W] = word_mode_d ? word_d[LANE_W-1:BYTE_W] : '0;
  assign shared_out                = word_mode_d && word_d[WORD_W-1];

  // Enables follow the live mode so the shared pin releases at once.
  assign data_oe[BYTE_W-1:0]      = {BYTE_W{drive}};
  assign data_oe[LANE_W-1:BYTE_W] = {UP_W{drive && word_mode}};
  assign shared_oe                = drive && word_mode;
endmodule

// File: rtl/rom_bw_port.sv
`timescale 1ns/1ps
module rom_bw_port
  import rom_bw_pkg::*;
#(
  parameter int          DEPTH    = 256,
  parameter int          LATENCY  = 3,
  parameter oe_pol_e     OE_POL   = OE_ACT_LOW,
  parameter logic [15:0] IMG_SEED = 16'h1234
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIN_ADDR_W-1:0] addr,
  input  logic                  word_mode,
  input  logic                  ce_n,
  input  logic                  oe_in,
  input  logic                  shared_in,
  output logic [LANE_W-1:0]     data_out,
  output logic [LANE_W-1:0]     data_oe,
  output logic                  shared_out,
  output logic                  shared_oe
);
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SB_W   = 2;
  localparam int PIPE_W = WORD_W + SB_W;
  localparam int EXTRA  = (LATENCY > 1) ? LATENCY - 1 : 0;

  logic [AW-1:0]     word_idx;
  logic              hi_byte;
  logic [WORD_W-1:0] word_q;
  logic [SB_W-1:0]   sb_q;
  logic [PIPE_W-1:0] pipe_out;

  rom_addr_map #(.IN_W(PIN_ADDR_W), .AW(AW)) u_map (
    .addr(addr), .word_mode(word_mode), .shared_in(shared_in),
    .word_idx(word_idx), .hi_byte(hi_byte)
  );

  rom_image #(.AW(AW), .SB_W(SB_W), .IMG_SEED(IMG_SEED)) u_img (
    .clk(clk), .rst_n(rst_n), .word_idx(word_idx),
    .sb_in({word_mode, hi_byte}), .word_q(word_q), .sb_q(sb_q)
  );

  rom_delay #(.W(PIPE_W), .STAGES(EXTRA)) u_dly (
    .clk(clk), .rst_n(rst_n), .d({sb_q, word_q}), .q(pipe_out)
  );

  rom_lane_steer #(.OE_POL(OE_POL)) u_steer (
    .word_d(pipe_out[WORD_W-1:0]),
    .word_mode_d(pipe_out[PIPE_W-1]),
    .hi_byte_d(pipe_out[PIPE_W-2]),
    .word_mode(word_mode), .ce_n(ce_n), .oe_in(oe_in),
    .data_out(data_out), .data_oe(data_oe),
    .shared_out(shared_out), .shared_oe(shared_oe)
  );
endmodule

// File: rtl/rom_bw_port_chk.sv
`timescale 1ns/1ps
module rom_bw_port_chk
  import rom_bw_pkg::*;
#(
  parameter oe_pol_e OE_POL = OE_ACT_LOW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_mode,
  input logic              ce_n,
  input logic              oe_in,
  input logic [LANE_W-1:0] data_oe,
  input logic              shared_oe
);
  logic oe_asserted;
  assign oe_asserted = (OE_POL == OE_ACT_HIGH) ? oe_in :
                       (OE_POL == OE_ACT_LOW)  ? !oe_in : 1'b1;

  assert_ce_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (data_oe == '0 && !shared_oe));

  assert_byte_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (data_oe[LANE_W-1:BYTE_W] == '0 && !shared_oe));

  assert_word_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && data_oe[0]) |-> (&data_oe && shared_oe));

  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe[0] == (!ce_n && oe_asserted));

  assert_low_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(data_oe[BYTE_W-1:0]) inside {0, BYTE_W});
endmodule

bind rom_bw_port rom_bw_port_chk #(.OE_POL(OE_POL)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .ce_n(ce_n),
  .oe_in(oe_in), .data_oe(data_oe), .shared_oe(shared_oe)
);

// File: tb/tb_rom_bw_port.sv
`timescale 1ns/1ps
module tb_rom_bw_port;
  import rom_bw_pkg::*;

  localparam int          DEPTH = 256;
  localparam int          LAT   = 3;
  localparam logic [15:0] SEED  = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] addr = '0;
  logic        word_mode = 1'b1;
  logic        ce_n = 1'b1;
  logic        oe_in = 1'b0;
  logic        shared_in = 1'b0;

  logic [14:0] dout [3];
  logic [14:0] doe  [3];
  logic        sout [3];
  logic        soe  [3];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rom_bw_port #(.DEPTH(DEPTH), .LATENCY(LAT), .OE_POL(OE_ACT_LOW), .IMG_SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .word_mode(word_mode), .ce_n(ce_n),
    .oe_in(oe_in), .shared_in(shared_in), .data_out(dout[0]), .data_oe(doe[0]),
    .shared_out(sout[0]), .shared_oe(soe[0]));
  rom_bw_port #(.DEPTH(DEPTH), .LATENCY(LAT), .OE_POL(OE_ACT_HIGH), .IMG_SEED(SEED)) dut_hi (
    .clk(clk), .rst_n(rst_n), .addr(addr), .word_mode(word_mode), .ce_n(ce_n),
    .oe_in(oe_in), .shared_in(shared_in), .data_out(dout[1]), .data_oe(doe[1]),
    .shared_out(sout[1]), .shared_oe(soe[1]));
  rom_bw_port #(.DEPTH(DEPTH), .LATENCY(LAT), .OE_POL(OE_IGNORE), .IMG_SEED(SEED)) dut_ig (
    .clk(clk), .rst_n(rst_n), .addr(addr), .word_mode(word_mode), .ce_n(ce_n),
    .oe_in(oe_in), .shared_in(shared_in), .data_out(dout[2]), .data_oe(doe[2]),
    .shared_out(sout[2]), .shared_oe(soe[2]));

  // R8 image, R9 wrap
  function automatic logic [15:0] ref_word(input logic [21:0] a);
    int unsigned loc;
    int unsigned v;
    loc = a % DEPTH;
    v = (loc * 40503 + SEED) ^ (loc << 5);
    return v[15:0];
  endfunction

  // polarity index: 0 active-low, 1 active-high, 2 ignored (R6)
  function automatic bit ref_drive(input int k, input bit cen, input bit oe);
    if (cen) return 0;
    if (k == 0) return !oe;
    if (k == 1) return oe;
    return 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_enables(input string req);
    for (int k = 0; k < 3; k++) begin
      bit d;
      d = ref_drive(k, ce_n, oe_in);
      chk(req, {17'b0, doe[k]}, {17'b0, {7{d && word_mode}}, {8{d}}});
      chk(req, {31'b0, soe[k]}, {31'b0, d && word_mode});
    end
  endtask

  task automatic check_data(input string req, input logic [21:0] a, input bit wm, input bit sh);
    logic [15:0] w;
    logic [14:0] ed;
    bit es;
    w = ref_word(a);
    if (wm) begin ed = w[14:0]; es = w[15]; end
    else begin ed = {7'b0, sh ? w[15:8] : w[7:0]}; es = 1'b0; end
    for (int k = 0; k < 3; k++) begin
      chk(req, {17'b0, dout[k]}, {17'b0, ed});
      chk(req, {31'b0, sout[k]}, {31'b0, es});
    end
  endtask

  task automatic do_read(input string req, input logic [21:0] a, input bit wm,
                         input bit sh, input bit cen, input bit oe);
    @(negedge clk);
    addr = a; word_mode = wm; shared_in = sh; ce_n = cen; oe_in = oe;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    check_data(req, a, wm, sh);
    check_enables(req);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R10 reset state, R5 chip disabled
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R10", {17'b0, dout[k]}, 32'd0);
      chk("R10", {31'b0, sout[k]}, 32'd0);
    end
    check_enables("R5");
    rst_n = 1'b1;

    // R1 word read, shared_in ignored in word mode
    do_read("R1", 22'd5, 1, 0, 0, 0);
    do_read("R1", 22'd5, 1, 1, 0, 0);
    // R2 both byte halves, R4 upper lanes floating
    do_read("R2", 22'd77, 0, 0, 0, 0);
    do_read("R2", 22'd77, 0, 1, 0, 0);
    // R6 each oe level, R5 ce off
    do_read("R6", 22'd9, 1, 0, 0, 1);
    do_read("R5", 22'd9, 1, 0, 1, 0);
    do_read("R5", 22'd9, 0, 1, 1, 1);
    // R9 wrap: upper address bits ignored
    do_read("R9", 22'h3FFF00 | 22'd3, 1, 0, 0, 0);
    do_read("R9", 22'h2AAA00 | 22'd255, 0, 1, 0, 0);
    // R8 boundaries of the image
    do_read("R8", 22'd0, 1, 0, 0, 0);
    do_read("R8", 22'd255, 1, 0, 0, 0);

    // R7 latency: data changes only after LAT edges
    do_read("R7", 22'd10, 1, 0, 0, 0);
    @(negedge clk);
    addr = 22'd11;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check_data("R7", 22'd10, 1, 0);
    @(negedge clk);
    check_data("R7", 22'd11, 1, 0);

    // R4 / R7: enables fall in the same cycle the mode goes low
    @(negedge clk);
    word_mode = 1'b0;
    #1;
    check_enables("R4");
    @(negedge clk);
    word_mode = 1'b1;
    #1;
    check_enables("R3");

    // Random mix of all modes and enables (R1 R2 R3 R6)
    for (int i = 0; i < 300; i++) begin
      logic [21:0] a;
      a = 22'($urandom);
      do_read("R1/R2/R3/R6", a, 1'($urandom), 1'($urandom),
              ($urandom % 4) == 0, 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule